// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries single 36-bit messages between two ports that run on unrelated clocks. There is one mailbox for each direction. Port A posts into the first mailbox and port B collects from it. Port B posts into the second mailbox and port A collects from it. Each mailbox has an active-low full flag in its writer's clock domain. The flag goes LOW on the edge that posts a word. While the flag is LOW, further posts are dropped. The flag returns HIGH once the reader's collection has crossed back into the writer's domain.

The crossing uses a toggle handshake. The writer flips a toggle bit when it posts a word. The reader flips a toggle bit of its own when it collects the word. Each toggle bit passes through a two-flop synchroniser into the opposite domain. The data register only changes while its writer sees the mailbox as empty, so the reader always samples a settled word. Each port also has a read-data bus. On that bus, a mailbox select input chooses between the mailbox contents and an externally supplied FIFO output word. The two FIFO-path resets each clear the mailbox that travels in the same direction.

Top module: `mbx_dual_clk`

## Requirements
- R1: On a `clk_a` rising edge where `a_op_en`=1, `a_wr`=1 (write), `a_mbx_sel`=1 and `mb1_full_n`=1, the word on `a_wdata` is stored in mailbox 1, and `mb1_full_n` reads 0 after that edge.
- R2: A port-A mailbox write on an edge where `mb1_full_n` is 0 is ignored, and mailbox 1 keeps its earlier word. The first write that is accepted is the first one presented on an edge where the flag already reads 1.
- R3: A port-B mailbox read (`b_op_en`=1, `b_rd_wr`=1, `b_mbx_sel`=1) of a mailbox 1 that port B sees as full returns `mb1_full_n` to 1 within four `clk_a` cycles. `mb1_full_n` does not rise in any other way except reset.
- R4: Mailbox 2 mirrors R1 to R3 in the other direction. A port-B write (`b_op_en`=1, `b_rd_wr`=0, `b_mbx_sel`=1) with `mb2_full_n`=1 stores `b_wdata` and drives `mb2_full_n` to 0. Writes are ignored while the flag is 0. A port-A read (`a_op_en`=1, `a_wr`=0, `a_mbx_sel`=1) returns the flag to 1 within four `clk_b` cycles.
- R5: While `rst_ab_n` is 0, `mb1_full_n` is 1 and mailbox 1 holds zero. Mailbox 2 and its flag are not affected.
- R6: While `rst_ba_n` is 0, `mb2_full_n` is 1 and mailbox 2 holds zero. Mailbox 1 and its flag are not affected.
- R7: `a_rdata` shows mailbox 2 when `a_wr`=0 and `a_mbx_sel`=1. It shows `a_fifo_q` when `a_wr`=0 and `a_mbx_sel`=0. It is all zeros when `a_wr`=1.
- R8: `b_rdata` shows mailbox 1 when `b_rd_wr`=1 and `b_mbx_sel`=1. It shows `b_fifo_q` when `b_rd_wr`=1 and `b_mbx_sel`=0. It is all zeros when `b_rd_wr`=0, which is the write polarity opposite to port A.
- R9: A mailbox read made while the reader sees that mailbox as empty has no effect. A word posted afterwards keeps its flag LOW until it is actually collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_ab_n | input | 1 | Active-low reset of the A-to-B path, clears mailbox 1 |
| rst_ba_n | input | 1 | Active-low reset of the B-to-A path, clears mailbox 2 |
| a_op_en | input | 1 | Port A operation enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mbx_sel | input | 1 | Port A mailbox select: 1 mailbox, 0 FIFO path |
| a_wdata | input | 36 | Port A write data |
| a_fifo_q | input | 36 | FIFO output word presented on port A |
| a_rdata | output | 36 | Port A read data |
| mb1_full_n | output | 1 | Mailbox 1 full flag, active low, in the clk_a domain |
| clk_b | input | 1 | Port B clock |
| b_op_en | input | 1 | Port B operation enable |
| b_rd_wr | input | 1 | Port B direction: 1 read, 0 write |
| b_mbx_sel | input | 1 | Port B mailbox select: 1 mailbox, 0 FIFO path |
| b_wdata | input | 36 | Port B write data |
| b_fifo_q | input | 36 | FIFO output word presented on port B |
| b_rdata | output | 36 | Port B read data |
| mb2_full_n | output | 1 | Mailbox 2 full flag, active low, in the clk_b domain |

## Verification
Two events can meet on the same port-A edge: a new mailbox write, and the arrival of the synchronised collection that frees the mailbox. The bench provokes this by having port B collect mailbox 1. Port A then presents a write with fresh data on every cycle until one of them is accepted. Each attempt's outcome is judged by the flag level seen just before its edge, and port B must later read exactly the word from the first attempt that met a HIGH flag. The reference model also tracks the flag through the clear window and flags any attempt that lands or is lost against that rule.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  localparam int unsigned MBX_WIDTH_DEF   = 36;
  localparam int unsigned MBX_SYNC_DEF    = 2;

  // Decoded mailbox request on one port
  typedef struct packed {
    logic post;
    logic take;
  } mbx_req_t;
endpackage

// File: rtl/mbx_rst_sync.sv
`timescale 1ns/1ps
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/mbx_bit_sync.sv
`timescale 1ns/1ps
module mbx_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
`timescale 1ns/1ps
module mbx_channel #(
  parameter int unsigned W      = 36,
  parameter int unsigned STAGES = 2
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         post,
  input  logic [W-1:0] wdata,
  output logic         full_n_w,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         take,
  output logic [W-1:0] word_q
);
  // writer domain
  logic wtog_q, wtog_d, rtog_in_w, full_w, post_ok;
  // reader domain
  logic rtog_q, rtog_d, wtog_in_r, full_r, take_ok;

  always_comb begin
    full_w  = wtog_q ^ rtog_in_w;
    post_ok = post & ~full_w;
    wtog_d  = wtog_q ^ post_ok;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wtog_q <= 1'b0;
      word_q <= '0;
    end else begin
      wtog_q <= wtog_d;
      if (post_ok) word_q <= wdata;
    end
  end

  assign full_n_w = ~full_w;

  always_comb begin
    full_r  = wtog_in_r ^ rtog_q;
    take_ok = take & full_r;
    rtog_d  = rtog_q ^ take_ok;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) rtog_q <= 1'b0;
    else         rtog_q <= rtog_d;
  end

  mbx_bit_sync #(.STAGES(STAGES)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wtog_q), .q(wtog_in_r)
  );

  mbx_bit_sync #(.STAGES(STAGES)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rtog_q), .q(rtog_in_w)
  );
endmodule

// File: rtl/mbx_dual_clk.sv
`timescale 1ns/1ps
module mbx_dual_clk
  import mbx_pkg::*;
#(
  parameter int unsigned W      = MBX_WIDTH_DEF,
  parameter int unsigned STAGES = MBX_SYNC_DEF
) (
  input  logic         clk_a,
  input  logic         rst_ab_n,
  input  logic         rst_ba_n,
  input  logic         a_op_en,
  input  logic         a_wr,
  input  logic         a_mbx_sel,
  input  logic [W-1:0] a_wdata,
  input  logic [W-1:0] a_fifo_q,
  output logic [W-1:0] a_rdata,
  output logic         mb1_full_n,
  input  logic         clk_b,
  input  logic         b_op_en,
  input  logic         b_rd_wr,
  input  logic         b_mbx_sel,
  input  logic [W-1:0] b_wdata,
  input  logic [W-1:0] b_fifo_q,
  output logic [W-1:0] b_rdata,
  output logic         mb2_full_n
);
  localparam logic [W-1:0] IDLE_WORD = '0;

  logic rst_ab_a_n, rst_ab_b_n, rst_ba_a_n, rst_ba_b_n;
  mbx_req_t req_a, req_b;
  logic [W-1:0] mail1_q, mail2_q;

  mbx_rst_sync #(.STAGES(STAGES)) u_rs_ab_a (.clk(clk_a), .arst_n(rst_ab_n), .srst_n(rst_ab_a_n));
  mbx_rst_sync #(.STAGES(STAGES)) u_rs_ab_b (.clk(clk_b), .arst_n(rst_ab_n), .srst_n(rst_ab_b_n));
  mbx_rst_sync #(.STAGES(STAGES)) u_rs_ba_a (.clk(clk_a), .arst_n(rst_ba_n), .srst_n(rst_ba_a_n));
  mbx_rst_sync #(.STAGES(STAGES)) u_rs_ba_b (.clk(clk_b), .arst_n(rst_ba_n), .srst_n(rst_ba_b_n));

  // Port A: a_wr HIGH writes; port B: b_rd_wr LOW writes
  always_comb begin
    req_a.post = a_op_en &  a_wr    & a_mbx_sel;
    req_a.take = a_op_en & ~a_wr    & a_mbx_sel;
    req_b.post = b_op_en & ~b_rd_wr & b_mbx_sel;
    req_b.take = b_op_en &  b_rd_wr & b_mbx_sel;
  end

  mbx_channel #(.W(W), .STAGES(STAGES)) u_mail1 (
    .wclk(clk_a), .wrst_n(rst_ab_a_n), .post(req_a.post), .wdata(a_wdata),
    .full_n_w(mb1_full_n),
    .rclk(clk_b), .rrst_n(rst_ab_b_n), .take(req_b.take), .word_q(mail1_q)
  );

  mbx_channel #(.W(W), .STAGES(STAGES)) u_mail2 (
    .wclk(clk_b), .wrst_n(rst_ba_b_n), .post(req_b.post), .wdata(b_wdata),
    .full_n_w(mb2_full_n),
    .rclk(clk_a), .rrst_n(rst_ba_a_n), .take(req_a.take), .word_q(mail2_q)
  );

  always_comb begin
    if (a_wr)           a_rdata = IDLE_WORD;
    else if (a_mbx_sel) a_rdata = mail2_q;
    else                a_rdata = a_fifo_q;
  end

  always_comb begin
    if (!b_rd_wr)       b_rdata = IDLE_WORD;
    else if (b_mbx_sel) b_rdata = mail1_q;
    else                b_rdata = b_fifo_q;
  end
endmodule

// File: rtl/mbx_dual_clk_chk.sv
`timescale 1ns/1ps
module mbx_dual_clk_chk #(
  parameter int unsigned W = 36
) (
  input logic         clk_a,
  input logic         clk_b,
  input logic         srst_ab_a_n,
  input logic         srst_ba_b_n,
  input logic         a_op_en,
  input logic         a_wr,
  input logic         a_mbx_sel,
  input logic         b_op_en,
  input logic         b_rd_wr,
  input logic         b_mbx_sel,
  input logic         mb1_full_n,
  input logic         mb2_full_n,
  input logic [W-1:0] mail1_q,
  input logic [W-1:0] mail2_q
);
  p_post_sets_flag_r1: assert property (@(posedge clk_a) disable iff (!srst_ab_a_n)
    (a_op_en && a_wr && a_mbx_sel && mb1_full_n) |=> !mb1_full_n);

  p_full_holds_word_r2: assert property (@(posedge clk_a) disable iff (!srst_ab_a_n)
    !mb1_full_n |=> $stable(mail1_q));

  p_post_sets_flag_r4: assert property (@(posedge clk_b) disable iff (!srst_ba_b_n)
    (b_op_en && !b_rd_wr && b_mbx_sel && mb2_full_n) |=> !mb2_full_n);

  p_full_holds_word_r4: assert property (@(posedge clk_b) disable iff (!srst_ba_b_n)
    !mb2_full_n |=> $stable(mail2_q));

  p_reset_frees_r5: assert property (@(posedge clk_a)
    !srst_ab_a_n |-> (mb1_full_n && mail1_q == '0));

  p_reset_frees_r6: assert property (@(posedge clk_b)
    !srst_ba_b_n |-> (mb2_full_n && mail2_q == '0));
endmodule

bind mbx_dual_clk mbx_dual_clk_chk #(.W(W)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b),
  .srst_ab_a_n(rst_ab_a_n), .srst_ba_b_n(rst_ba_b_n),
  .a_op_en(a_op_en), .a_wr(a_wr), .a_mbx_sel(a_mbx_sel),
  .b_op_en(b_op_en), .b_rd_wr(b_rd_wr), .b_mbx_sel(b_mbx_sel),
  .mb1_full_n(mb1_full_n), .mb2_full_n(mb2_full_n),
  .mail1_q(mail1_q), .mail2_q(mail2_q)
);

// File: tb/mbx_dual_clk_tb.sv
`timescale 1ns/1ps
module mbx_dual_clk_tb;
  localparam int W = 36;
  localparam int LIMIT_CYC = 200000;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_ab_n = 1'b0, rst_ba_n = 1'b0;
  logic a_op_en = 1'b0, a_wr = 1'b0, a_mbx_sel = 1'b0;
  logic [W-1:0] a_wdata = '0, a_fifo_q = '0;
  logic b_op_en = 1'b0, b_rd_wr = 1'b1, b_mbx_sel = 1'b0;
  logic [W-1:0] b_wdata = '0, b_fifo_q = '0;
  logic [W-1:0] a_rdata, b_rdata;
  logic mb1_full_n, mb2_full_n;

  always #5 clk_a = ~clk_a;   // 100 MHz
  always #7 clk_b = ~clk_b;   // unrelated port-B clock

  mbx_dual_clk u_dut (
    .clk_a(clk_a), .rst_ab_n(rst_ab_n), .rst_ba_n(rst_ba_n),
    .a_op_en(a_op_en), .a_wr(a_wr), .a_mbx_sel(a_mbx_sel),
    .a_wdata(a_wdata), .a_fifo_q(a_fifo_q), .a_rdata(a_rdata), .mb1_full_n(mb1_full_n),
    .clk_b(clk_b), .b_op_en(b_op_en), .b_rd_wr(b_rd_wr), .b_mbx_sel(b_mbx_sel),
    .b_wdata(b_wdata), .b_fifo_q(b_fifo_q), .b_rdata(b_rdata), .mb2_full_n(mb2_full_n)
  );

  // reference model
  logic [W-1:0] m_mail1 = '0, m_mail2 = '0;
  bit m1_full = 0, m2_full = 0;
  bit clr1_pend = 0, clr2_pend = 0;
  int clr1_cnt = 0, clr2_cnt = 0;
  int vectors = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] won_word;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // port-A side comparison, 1 ns before each clk_a rising edge
  always begin
    @(negedge clk_a); #4;
    chk("R7", a_rdata, a_wr ? '0 : (a_mbx_sel ? m_mail2 : a_fifo_q));
    if (clr1_pend) begin
      if (mb1_full_n) begin m1_full = 0; clr1_pend = 0; vectors++; end
      else if (++clr1_cnt > 4) begin
        chk("R3", {35'd0, mb1_full_n}, 36'd1); clr1_pend = 0; m1_full = 0;
      end
    end else chk("R1", {35'd0, mb1_full_n}, {35'd0, !m1_full});
  end

  // port-B side comparison, 1 ns before each clk_b rising edge
  always begin
    @(negedge clk_b); #6;
    chk("R8", b_rdata, !b_rd_wr ? '0 : (b_mbx_sel ? m_mail1 : b_fifo_q));
    if (clr2_pend) begin
      if (mb2_full_n) begin m2_full = 0; clr2_pend = 0; vectors++; end
      else if (++clr2_cnt > 4) begin
        chk("R4", {35'd0, mb2_full_n}, 36'd1); clr2_pend = 0; m2_full = 0;
      end
    end else chk("R4", {35'd0, mb2_full_n}, {35'd0, !m2_full});
  end

  task automatic a_op(input bit en, input bit wr, input bit sel,
                      input logic [W-1:0] wd, input logic [W-1:0] fq);
    bit post_ok, take_ok;
    @(negedge clk_a);
    a_op_en = en; a_wr = wr; a_mbx_sel = sel; a_wdata = wd; a_fifo_q = fq;
    post_ok = en && wr && sel && (clr1_pend ? mb1_full_n : !m1_full);
    take_ok = en && !wr && sel && m2_full && !clr2_pend;
    @(posedge clk_a);
    if (post_ok) begin m_mail1 = wd; m1_full = 1; clr1_pend = 0; end
    if (take_ok) begin clr2_pend = 1; clr2_cnt = 0; end
  endtask

  task automatic b_op(input bit en, input bit rdwr, input bit sel,
                      input logic [W-1:0] wd, input logic [W-1:0] fq);
    bit post_ok, take_ok;
    @(negedge clk_b);
    b_op_en = en; b_rd_wr = rdwr; b_mbx_sel = sel; b_wdata = wd; b_fifo_q = fq;
    post_ok = en && !rdwr && sel && (clr2_pend ? mb2_full_n : !m2_full);
    take_ok = en && rdwr && sel && m1_full && !clr1_pend;
    @(posedge clk_b);
    if (post_ok) begin m_mail2 = wd; m2_full = 1; clr2_pend = 0; end
    if (take_ok) begin clr1_pend = 1; clr1_cnt = 0; end
  endtask

  task automatic a_idle(input int n);
    for (int i = 0; i < n; i++) a_op(0, 0, 0, '0, a_fifo_q);
  endtask

  task automatic b_idle(input int n);
    for (int i = 0; i < n; i++) b_op(0, 1, 0, '0, b_fifo_q);
  endtask

  task automatic pulse_ab_reset();
    @(negedge clk_a);
    rst_ab_n = 0; m_mail1 = '0; m1_full = 0; clr1_pend = 0;
    repeat (4) @(negedge clk_b);
    rst_ab_n = 1;
    b_idle(5);
  endtask

  task automatic pulse_ba_reset();
    @(negedge clk_b);
    rst_ba_n = 0; m_mail2 = '0; m2_full = 0; clr2_pend = 0;
    repeat (4) @(negedge clk_b);
    rst_ba_n = 1;
    b_idle(5);
  endtask

  initial begin
    repeat (6) @(negedge clk_b);
    // reset state, R5 R6
    @(negedge clk_a); #4;
    chk("R5", {35'd0, mb1_full_n}, 36'd1);
    @(negedge clk_b); #6;
    chk("R6", {35'd0, mb2_full_n}, 36'd1);
    rst_ab_n = 1; rst_ba_n = 1;
    a_idle(5); b_idle(5);

    // R1: post to mailbox 1
    a_op(1, 1, 1, 36'h1_2345_6789, '0);
    a_idle(1);
    @(negedge clk_a); #4; chk("R1", {35'd0, mb1_full_n}, 36'd0);
    // R2: second post blocked
    a_op(1, 1, 1, 36'hF_0000_000F, '0);
    a_idle(2);
    b_idle(6);
    // R3 / R2: collect word 1
    b_op(1, 1, 1, '0, '0);
    #6; chk("R2", b_rdata, 36'h1_2345_6789);
    b_idle(2); a_idle(6);
    @(negedge clk_a); #4; chk("R3", {35'd0, mb1_full_n}, 36'd1);

    // R4: mailbox 2 in the other direction
    b_op(1, 0, 1, 36'hA_BCDE_F012, '0);
    b_op(1, 0, 1, 36'h5_5555_5555, '0);   // blocked
    b_idle(1);
    @(negedge clk_b); #6; chk("R4", {35'd0, mb2_full_n}, 36'd0);
    a_idle(6);
    a_op(1, 0, 1, '0, 36'h0_0000_0777);
    a_idle(1); b_idle(6);
    @(negedge clk_b); #6; chk("R4", {35'd0, mb2_full_n}, 36'd1);

    // R7 R8: output selection and write polarity
    for (int i = 0; i < 4; i++) begin
      a_op(0, 0, 0, '0, 36'h3_0000_0000 + 36'(i * 37));
      a_op(0, 1, 1, '0, 36'h3_FFFF_0000);
      b_op(0, 1, 0, '0, 36'hC_0000_0000 + 36'(i * 91));
      b_op(0, 0, 1, '0, 36'hC_FFFF_0000);
    end
    a_op(0, 0, 1, '0, 36'h1);
    b_op(0, 1, 1, '0, 36'h2);

    // R9: read of an empty mailbox has no effect
    a_op(1, 0, 1, '0, '0);
    a_idle(6); b_idle(2);
    b_op(1, 0, 1, 36'h9_0909_0909, '0);
    b_idle(10);
    @(negedge clk_b); #6; chk("R9", {35'd0, mb2_full_n}, 36'd0);
    a_op(1, 0, 1, '0, '0);
    #4; chk("R9", a_rdata, 36'h9_0909_0909);
    a_idle(2); b_idle(6);

    // R2 collision: posts every cycle while the collection crosses over
    a_op(1, 1, 1, 36'h7_7777_0000, '0);
    a_idle(1); b_idle(6);
    b_op(1, 1, 1, '0, '0);
    b_idle(1);
    won_word = '0;
    for (int i = 1; i < 12; i++) begin
      a_op(1, 1, 1, 36'h8_0000_0000 + 36'(i), '0);
      if (won_word == '0 && m_mail1 != 36'h7_7777_0000) won_word = m_mail1;
    end
    a_idle(2); b_idle(6);
    b_op(1, 1, 1, '0, '0);
    #6; chk("R2", b_rdata, won_word);
    b_idle(2); a_idle(6);

    // R5 R6: each path reset only touches its own mailbox
    a_op(1, 1, 1, 36'h4_4444_4444, '0);
    b_op(1, 0, 1, 36'h6_6666_6666, '0);
    a_idle(6); b_idle(6);
    pulse_ab_reset();
    a_idle(3);
    @(negedge clk_a); #4; chk("R5", {35'd0, mb1_full_n}, 36'd1);
    @(negedge clk_b); #6; chk("R5", {35'd0, mb2_full_n}, 36'd0);
    b_op(0, 1, 1, '0, '0);
    #6; chk("R5", b_rdata, '0);
    pulse_ba_reset();
    a_idle(3);
    @(negedge clk_b); #6; chk("R6", {35'd0, mb2_full_n}, 36'd1);
    a_op(0, 0, 1, '0, '0);
    #4; chk("R6", a_rdata, '0);
    a_idle(4); b_idle(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(LIMIT_CYC * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule